// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between eight serial TDM input lines and eight serial TDM output lines. A frame holds 32 eight-bit channels on every line, which gives 256 channel slots per frame in each direction. Each output slot has its own entry in a connection store. The entry either names any input line and channel whose byte is copied into that slot, or it holds a constant byte that is sent unchanged in the slot (message mode).

One system clock runs at the serial bit rate, and a frame pulse marks the first bit of channel 0. Received bytes are kept in two frame banks. Bytes captured during one frame are switched out during the next frame, so an output frame never takes bytes from two different input frames.

Each output line has a per-slot drive enable, gated by an external drive-enable input. A separate serial control line carries one bit per output slot and runs one channel ahead of the data. A simple synchronous write port loads a control register and both halves of the connection store.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every drive enable and the control line are low, and the connection store and control register hold zero.
- R2: With high field bit 2 clear and control bit 6 clear, output line o sends in channel n the byte received on input line lo[7:5], channel lo[4:0], where lo is the low byte of entry {o,n}. The byte is sent most significant bit first, one bit per clock.
- R3: With high field bit 2 set, the slot sends its own low byte.
- R4: While the drive-enable input is low, every output enable is low.
- R5: While the drive-enable input is high and control bit 6 is clear, a slot's output enable equals bit 0 of its high field.
- R6: With control bit 6 set, every slot is driven and sends its own low byte, whatever high bits 2 and 0 hold.
- R7: During bit b (0 = first) of channel c, the control line carries high bit 1 of output line b, channel (c+1) mod 32. Channel 31 therefore carries the bits for channel 0 of the next frame.
- R8: A byte received in frame k is sent in frame k+1 only. This also holds when the source channel is at or after the destination channel, including source channel 31.
- R9: Write-port select codes: 0 is the control register, 1 is the low byte, 2 is the high field (data bits 2:0). The address is {line[2:0], channel[4:0]}. A write becomes visible after the clock edge that takes it. If the slot's fetch happens in that same cycle, the slot still uses the old entry in that frame and the new entry in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during bit 0 of channel 0 |
| sti_i | input | 8 | Serial input lines |
| ode_i | input | 1 | Global drive enable, low forces all enables off |
| reg_we_i | input | 1 | Write strobe |
| reg_sel_i | input | 2 | Write target: 0 control, 1 low byte, 2 high field |
| reg_addr_i | input | 8 | Entry address {line, channel} |
| reg_wdata_i | input | 8 | Write data |
| sto_o | output | 8 | Serial output lines |
| sto_oe_o | output | 8 | Per-line drive enable for the current slot |
| cst_o | output | 1 | Serial control line, one channel ahead |

## Verification
A host write can land on the very clock edge at which the switch fetches the entry for the next channel. The bench times a low-byte write so that it is taken on the fetch edge for line 2, channel 10. The slot must carry the old source byte in that frame and the new source byte in the following frame.

A second collision happens at the last bit of every frame. The capture of channel 31 and the fetch for channel 0 of the next frame meet in that cycle. Connections whose source channel is at or after the destination channel are checked against the previous frame's input pattern, and those checks are tagged as frame-buffering checks.

// File: rtl/tsi_pkg.sv
// Package: shared types and constants for the time-slot interchange switch.
// Assumes channel count is a power of two and bits per channel equal the
// number of lines (the control line serialises one bit per line).
package tsi_pkg;
    localparam int BYTE_W      = 8;
    localparam int ALL_MSG_BIT = 6;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LO   = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;

    // High field of a connection entry; bit order is msg=2, ctl=1, drv=0.
    typedef struct packed {
        logic msg;
        logic ctl;
        logic drv;
    } cm_hi_t;
endpackage

// File: rtl/tsi_timing.sv
// Module: frame position counter. Produces the bit/channel position of the
// current clock, the per-channel fetch strobe, the frame-end strobe and the
// bank selector for the receive store. Assumes a regular frame pulse.
module tsi_timing #(
    parameter int N_CHAN = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fp_i,
    output logic [$clog2(N_CHAN)+2:0]       pos,
    output logic                            load,
    output logic                            frame_end,
    output logic                            bank
);
    localparam int POSW = $clog2(N_CHAN) + 3;

    logic [POSW-1:0] cnt_q;

    // Current position: the frame pulse forces position zero.
    always_comb pos = fp_i ? '0 : cnt_q;

    assign load      = (pos[2:0] == 3'd7);
    assign frame_end = (pos == {POSW{1'b1}});

    // Advance the position counter every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= pos + 1'b1;
    end

    // Swap receive banks after the last bit of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         bank <= 1'b0;
        else if (frame_end) bank <= ~bank;
    end
endmodule

// File: rtl/tsi_rx_buf.sv
// Module: serial receive capture and two-bank frame store. Bytes of the
// current frame go to bank `bank`; reads come from the other bank, except at
// frame end where the bank being completed is read, with a bypass for the
// byte arriving in that same cycle.
module tsi_rx_buf #(
    parameter int N_STREAMS = 8,
    parameter int N_CHAN    = 32
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [N_STREAMS-1:0]                           sti,
    input  logic [$clog2(N_CHAN)+2:0]                      pos,
    input  logic                                           bank,
    input  logic                                           frame_end,
    input  logic [N_STREAMS-1:0][$clog2(N_STREAMS)-1:0]    rd_s,
    input  logic [N_STREAMS-1:0][$clog2(N_CHAN)-1:0]       rd_c,
    output logic [N_STREAMS-1:0][tsi_pkg::BYTE_W-1:0]      rd_byte
);
    import tsi_pkg::*;
    localparam int SW    = $clog2(N_STREAMS);
    localparam int CW    = $clog2(N_CHAN);
    localparam int POSW  = CW + 3;
    localparam int DEPTH = 2 * N_STREAMS * N_CHAN;

    logic [N_STREAMS-1:0][BYTE_W-2:0] sh_q;
    logic [N_STREAMS-1:0][BYTE_W-1:0] new_byte;
    logic [BYTE_W-1:0]                mem [DEPTH];
    logic [CW-1:0]                    cur_ch;
    logic                             rbank;

    assign cur_ch = pos[POSW-1:3];
    assign rbank  = frame_end ? bank : ~bank;

    // Deserialise each input line, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else for (int s = 0; s < N_STREAMS; s++)
            sh_q[s] <= {sh_q[s][BYTE_W-3:0], sti[s]};
    end

    generate
        for (genvar s = 0; s < N_STREAMS; s++) begin : g_new
            assign new_byte[s] = {sh_q[s], sti[s]};
        end
    endgenerate

    // Store every completed byte into the write bank.
    always_ff @(posedge clk) begin
        if (pos[2:0] == 3'd7)
            for (int s = 0; s < N_STREAMS; s++)
                mem[{bank, SW'(s), cur_ch}] <= new_byte[s];
    end

    // One read port per output line, with same-cycle bypass at frame end.
    generate
        for (genvar o = 0; o < N_STREAMS; o++) begin : g_rd
            always_comb begin
                if (frame_end && rd_c[o] == cur_ch)
                    rd_byte[o] = new_byte[rd_s[o]];
                else
                    rd_byte[o] = mem[{rbank, rd_s[o], rd_c[o]}];
            end
        end
    endgenerate
endmodule

// File: rtl/tsi_conn_mem.sv
// Module: control register and connection store (low byte plus 3-bit high
// field per output slot), with one write port and a read port per output
// line plus one for the control line. Reads see contents before a write
// taken on the same edge.
module tsi_conn_mem #(
    parameter int N_STREAMS = 8,
    parameter int N_CHAN    = 32
) (
    input  logic                                                        clk,
    input  logic                                                        rst_n,
    input  logic                                                        we,
    input  logic [1:0]                                                  sel,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHAN)-1:0]                 addr,
    input  logic [tsi_pkg::BYTE_W-1:0]                                  wdata,
    input  logic [N_STREAMS-1:0][$clog2(N_STREAMS)+$clog2(N_CHAN)-1:0]  rd_addr,
    output logic [N_STREAMS-1:0][tsi_pkg::BYTE_W-1:0]                   rd_lo,
    output tsi_pkg::cm_hi_t [N_STREAMS-1:0]                             rd_hi,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHAN)-1:0]                 ctl_addr,
    output logic                                                        ctl_bit,
    output logic [tsi_pkg::BYTE_W-1:0]                                  ctrl
);
    import tsi_pkg::*;
    localparam int AW    = $clog2(N_STREAMS) + $clog2(N_CHAN);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] lo_q [DEPTH];
    cm_hi_t            hi_q [DEPTH];

    // Apply host writes; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (we) begin
            case (sel)
                SEL_CTRL: ctrl       <= wdata;
                SEL_LO:   lo_q[addr] <= wdata;
                SEL_HI:   hi_q[addr] <= cm_hi_t'(wdata[2:0]);
                default:  ;
            endcase
        end
    end

    generate
        for (genvar o = 0; o < N_STREAMS; o++) begin : g_rd
            assign rd_lo[o] = lo_q[rd_addr[o]];
            assign rd_hi[o] = hi_q[rd_addr[o]];
        end
    endgenerate

    assign ctl_bit = hi_q[ctl_addr].ctl;
endmodule

// File: rtl/tsi_tx.sv
// Module: output serialisers, per-slot enable registers and control-line
// register. At each fetch strobe the next channel's byte and enable are
// loaded; otherwise the byte shifts out MSB first.
module tsi_tx #(
    parameter int N_STREAMS = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        load,
    input  logic                                        ode,
    input  logic                                        all_msg,
    input  logic [N_STREAMS-1:0][tsi_pkg::BYTE_W-1:0]   cm_lo,
    input  tsi_pkg::cm_hi_t [N_STREAMS-1:0]             cm_hi,
    input  logic [N_STREAMS-1:0][tsi_pkg::BYTE_W-1:0]   sw_byte,
    input  logic                                        ctl_next,
    output logic [N_STREAMS-1:0]                        sto,
    output logic [N_STREAMS-1:0]                        sto_oe,
    output logic                                        cst,
    output logic [N_STREAMS-1:0]                        slot_en
);
    import tsi_pkg::*;

    logic [N_STREAMS-1:0][BYTE_W-1:0] sh_q;

    // Load next slot's byte and enable, or shift the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            slot_en <= '0;
        end else begin
            for (int o = 0; o < N_STREAMS; o++) begin
                if (load) begin
                    sh_q[o]    <= (all_msg || cm_hi[o].msg) ? cm_lo[o] : sw_byte[o];
                    slot_en[o] <= all_msg || cm_hi[o].drv;
                end else begin
                    sh_q[o]    <= {sh_q[o][BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    // Register the control-line bit for the next bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) cst <= 1'b0;
        else        cst <= ctl_next;
    end

    generate
        for (genvar o = 0; o < N_STREAMS; o++) begin : g_out
            assign sto[o] = sh_q[o][BYTE_W-1];
        end
    endgenerate

    assign sto_oe = {N_STREAMS{ode}} & slot_en;
endmodule

// File: rtl/tsi_switch.sv
// Module: top of the time-slot interchange switch. Wires timing, receive
// store, connection store and transmit stages. Assumes N_STREAMS equals the
// bits per channel and the low byte is wide enough for {line, channel}.
module tsi_switch #(
    parameter int N_STREAMS = 8,
    parameter int N_CHAN    = 32
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        fp_i,
    input  logic [N_STREAMS-1:0]                        sti_i,
    input  logic                                        ode_i,
    input  logic                                        reg_we_i,
    input  logic [1:0]                                  reg_sel_i,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHAN)-1:0] reg_addr_i,
    input  logic [7:0]                                  reg_wdata_i,
    output logic [N_STREAMS-1:0]                        sto_o,
    output logic [N_STREAMS-1:0]                        sto_oe_o,
    output logic                                        cst_o
);
    import tsi_pkg::*;
    localparam int SW   = $clog2(N_STREAMS);
    localparam int CW   = $clog2(N_CHAN);
    localparam int POSW = CW + 3;
    localparam int AW   = SW + CW;

    logic [POSW-1:0]                  pos, nxt_pos;
    logic                             load, frame_end, bank_q;
    logic [CW-1:0]                    nxt_ch, cst_ch;
    logic [N_STREAMS-1:0][AW-1:0]     rd_addr;
    logic [N_STREAMS-1:0][BYTE_W-1:0] cm_lo, sw_byte;
    cm_hi_t [N_STREAMS-1:0]           cm_hi;
    logic [N_STREAMS-1:0][SW-1:0]     rx_s;
    logic [N_STREAMS-1:0][CW-1:0]     rx_c;
    logic [AW-1:0]                    cst_addr;
    logic                             ctl_next;
    logic [BYTE_W-1:0]                ctrl_q;
    logic [N_STREAMS-1:0]             slot_en;

    tsi_timing #(.N_CHAN(N_CHAN)) u_tim (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .pos(pos),
        .load(load), .frame_end(frame_end), .bank(bank_q)
    );

    assign nxt_ch   = pos[POSW-1:3] + 1'b1;
    assign nxt_pos  = pos + 1'b1;
    assign cst_ch   = nxt_pos[POSW-1:3] + 1'b1;
    assign cst_addr = {nxt_pos[SW-1:0], cst_ch};

    generate
        for (genvar o = 0; o < N_STREAMS; o++) begin : g_map
            assign rd_addr[o] = {SW'(o), nxt_ch};
            assign rx_s[o]    = cm_lo[o][AW-1:CW];
            assign rx_c[o]    = cm_lo[o][CW-1:0];
        end
    endgenerate

    tsi_conn_mem #(.N_STREAMS(N_STREAMS), .N_CHAN(N_CHAN)) u_cm (
        .clk(clk), .rst_n(rst_n), .we(reg_we_i), .sel(reg_sel_i),
        .addr(reg_addr_i), .wdata(reg_wdata_i), .rd_addr(rd_addr),
        .rd_lo(cm_lo), .rd_hi(cm_hi), .ctl_addr(cst_addr),
        .ctl_bit(ctl_next), .ctrl(ctrl_q)
    );

    tsi_rx_buf #(.N_STREAMS(N_STREAMS), .N_CHAN(N_CHAN)) u_rx (
        .clk(clk), .rst_n(rst_n), .sti(sti_i), .pos(pos), .bank(bank_q),
        .frame_end(frame_end), .rd_s(rx_s), .rd_c(rx_c), .rd_byte(sw_byte)
    );

    tsi_tx #(.N_STREAMS(N_STREAMS)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(load), .ode(ode_i),
        .all_msg(ctrl_q[ALL_MSG_BIT]), .cm_lo(cm_lo), .cm_hi(cm_hi),
        .sw_byte(sw_byte), .ctl_next(ctl_next), .sto(sto_o),
        .sto_oe(sto_oe_o), .cst(cst_o), .slot_en(slot_en)
    );
endmodule

// File: rtl/tsi_switch_chk.sv
// Module: assertion checker for tsi_switch, attached by bind. Observes the
// frame position, bank selector, fetch strobe and slot enables.
module tsi_switch_chk #(
    parameter int NS   = 8,
    parameter int POSW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            load,
    input logic            all_msg,
    input logic [NS-1:0]   slot_en,
    input logic            cst,
    input logic [POSW-1:0] pos,
    input logic            bank
);
    // R1: reset leaves enables and control line low.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (slot_en == '0 && !cst));

    // R5: slot enables only change at a fetch edge.
    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(slot_en));

    // R6: with all-message mode, a fetch drives every line.
    p_all_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && all_msg) |=> (slot_en == {NS{1'b1}}));

    // R8: receive bank holds within a frame.
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != {POSW{1'b1}}) |=> $stable(bank));

    // R8: receive bank swaps after the last bit of a frame.
    p_bank_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == {POSW{1'b1}}) |=> (bank != $past(bank)));
endmodule

bind tsi_switch tsi_switch_chk #(.NS(N_STREAMS), .POSW(POSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .all_msg(ctrl_q[6]),
    .slot_en(slot_en), .cst(cst_o), .pos(pos), .bank(bank_q)
);

// File: tb/sim_tsi_switch.sv
// Bench: drives a frame-indexed arithmetic pattern on all input lines,
// programs the connection store, and compares every output bit, enable and
// control bit against a model computed from the requirements.
module sim_tsi_switch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp_i = 1'b0;
    logic [7:0] sti_i = '0;
    logic       ode_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [1:0] reg_sel_i = '0;
    logic [7:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] sto_o, sto_oe_o;
    logic       cst_o;

    int total = 0, bad = 0;
    int bpos = 0, bframe = 0;
    bit chk_on = 0;
    int coll_f = -10;

    logic [7:0] m_lo [256];
    logic [2:0] m_hi [256];
    logic [7:0] m_ctrl = '0;

    logic [7:0] exp_byte [8];
    bit         exp_en [8];
    string      exp_tag [8];
    bit         exp_cst = 0;

    always #2 clk = ~clk;

    tsi_switch u0 (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .sti_i(sti_i), .ode_i(ode_i),
        .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .sto_o(sto_o), .sto_oe_o(sto_oe_o),
        .cst_o(cst_o)
    );

    function automatic logic [7:0] din(int s, int c, int f);
        return 8'((s * 37 + c * 11 + f * 53 + 7) & 255);
    endfunction

    task automatic chk(bit ok, string tag, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s pos=%0d frame=%0d got=%0h exp=%0h", tag, bpos, bframe, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Bench frame position, aligned with the design's counter.
    always @(posedge clk) begin
        if (!rst_n) begin
            bpos <= 0; bframe <= 0;
        end else begin
            bpos <= (bpos == 255) ? 0 : bpos + 1;
            if (bpos == 255) bframe <= bframe + 1;
        end
    end

    // Drive frame pulse and serial inputs for the current position.
    always @(posedge clk) begin
        #1;
        fp_i = (bpos == 0);
        for (int s = 0; s < 8; s++) begin
            logic [7:0] b;
            b = din(s, bpos / 8, bframe);
            sti_i[s] = b[7 - bpos % 8];
        end
    end

    // Compare outputs of this cycle, then predict the next cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_on) begin
                for (int o = 0; o < 8; o++) begin
                    chk(sto_o[o] == exp_byte[o][7 - bpos % 8], exp_tag[o],
                        int'(sto_o[o]), int'(exp_byte[o][7 - bpos % 8]));
                    chk(sto_oe_o[o] == (ode_i & exp_en[o]),
                        !ode_i ? "R4" : (m_ctrl[6] ? "R6" : "R5"),
                        int'(sto_oe_o[o]), int'(ode_i & exp_en[o]));
                end
                chk(cst_o == exp_cst, "R7", int'(cst_o), int'(exp_cst));
            end
            begin
                int np, idx;
                np = (bpos + 1) % 256;
                idx = (np % 8) * 32 + ((np / 8 + 1) % 32);
                exp_cst = m_hi[idx][1];
            end
            if (bpos % 8 == 7) begin
                for (int o = 0; o < 8; o++) begin
                    int n, idx, f;
                    bit msg;
                    n = (bpos / 8 + 1) % 32;
                    idx = o * 32 + n;
                    f = (bpos == 255) ? bframe : bframe - 1;
                    msg = m_ctrl[6] | m_hi[idx][2];
                    exp_byte[o] = msg ? m_lo[idx]
                                      : din(int'(m_lo[idx][7:5]), int'(m_lo[idx][4:0]), f);
                    exp_en[o] = m_ctrl[6] | m_hi[idx][0];
                    if (o == 2 && n == 10 && (f + 1 == coll_f || f == coll_f))
                        exp_tag[o] = "R9";
                    else if (m_ctrl[6]) exp_tag[o] = "R6";
                    else if (m_hi[idx][2]) exp_tag[o] = "R3";
                    else if (int'(m_lo[idx][4:0]) >= n) exp_tag[o] = "R8";
                    else exp_tag[o] = "R2";
                end
            end
        end
    end

    // Write one register; at_pos >= 0 waits for that position of at_frame.
    task automatic wr(logic [1:0] sel, logic [7:0] addr, logic [7:0] data,
                      int at_pos, int at_frame);
        if (at_pos >= 0) begin
            do begin @(posedge clk); #1; end
            while (!(bpos == at_pos && bframe == at_frame));
        end else begin
            @(posedge clk); #1;
        end
        reg_we_i = 1'b1; reg_sel_i = sel; reg_addr_i = addr; reg_wdata_i = data;
        @(posedge clk);
        case (sel)
            2'd0: m_ctrl = data;
            2'd1: m_lo[addr] = data;
            2'd2: m_hi[addr] = data[2:0];
            default: ;
        endcase
        #1 reg_we_i = 1'b0;
    endtask

    task automatic wait_frames(int k);
        int t;
        t = bframe + k;
        while (bframe < t) @(posedge clk);
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < 256; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        for (int o = 0; o < 8; o++) begin exp_byte[o] = '0; exp_en[o] = 0; exp_tag[o] = "R2"; end
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(sto_oe_o == 8'h00, "R1", int'(sto_oe_o), 0);
        chk(cst_o == 1'b0, "R1", int'(cst_o), 0);
        ode_i = 1'b1;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(sto_oe_o == 8'h00, "R1", int'(sto_oe_o), 0);
        chk(cst_o == 1'b0, "R1", int'(cst_o), 0);

        // Switched and message connections, mixed enables and control bits.
        for (int o = 0; o < 8; o++) begin
            for (int n = 0; n < 32; n++) begin
                logic [7:0] a, lo;
                logic [2:0] hi;
                a  = 8'(o * 32 + n);
                hi = {1'(n % 5 == 0), 1'((o + n) % 3 == 0), 1'(n % 7 != 3)};
                lo = (n % 5 == 0) ? 8'((o * 16 + n) ^ 8'hA5)
                                  : {3'((o + 3) % 8), 5'((n * 7 + o) % 32)};
                wr(2'd1, a, lo, -1, 0);
                wr(2'd2, a, {5'd0, hi}, -1, 0);
            end
        end
        wait_frames(2);
        chk_on = 1;
        wait_frames(2);

        // R9: write taken on the fetch edge of line 2, channel 10.
        coll_f = bframe + 1;
        wr(2'd1, 8'(2 * 32 + 10), {3'd1, 5'd20}, 79, coll_f);
        wait_frames(3);

        // R4: global drive enable low for a full frame.
        ode_i = 1'b0;
        wait_frames(1);
        ode_i = 1'b1;
        wait_frames(1);

        // R6: all-message mode.
        wr(2'd0, 8'd0, 8'h40, -1, 0);
        wait_frames(2);

        chk_on = 0;
        finish_run();
    end
endmodule